// File: doc/BRIEF.md
# Next Program Counter Generator

This block picks the following fetch address for a processor that uses fixed 32-bit instructions. It holds the program counter and looks only at the fields of the fetched word that select a control transfer: the major opcode, the function code, the 16-bit branch offset and the 26-bit jump index. Together with an equality flag from the register comparator and a register value for indirect jumps, these give the next PC. It also gives the return address that a call writes to the link register.

The block is used in the fetch stage. Each cycle the fetch logic presents the word fetched at `pc`. The block shows the candidate address on `next_pc` in the same cycle. At the clock edge the PC takes that address when `step_en` is high. When `step_en` is low the PC holds. That is the block's only flow control. The pins are plain control and data pins with no valid/ready handshake. The stage that drives `step_en` applies any back-pressure by holding it low until the instruction can retire.

Top module: `npc_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pc` reads the parameter `RESET_PC` (default 0x0040_0000) until the first enabled clock edge.
- R2: At a rising clock edge with `step_en` high, `pc` takes the value `next_pc` showed before the edge. With `step_en` low, `pc` keeps its value.
- R3: In these cases `next_pc` is `pc + 4`: an opcode (bits 31:26) other than 000000, 000010, 000011, 000100 and 000101; an opcode of 000000 with a function code (bits 5:0) other than 001000; a branch whose condition is false.
- R4: Opcode 000100 (branch on equal) with `regs_eq` high gives `next_pc = pc + 4 + (sign-extended bits 15:0) * 4`.
- R5: Opcode 000101 (branch on not equal) with `regs_eq` low gives the same target as R4. With `regs_eq` high it gives `pc + 4`.
- R6: Opcode 000010 (jump) gives `next_pc = {pc[31:28], instr[25:0], 2'b00}`. A jump never changes the top four PC bits.
- R7: Opcode 000011 (jump and link) gives the same target as R6 and drives `link_we` high. `link_we` is low for every other instruction.
- R8: Opcode 000000 with function code 001000 (jump register) gives `next_pc = jr_target`, whatever `regs_eq` is.
- R9: `link_addr` always equals `pc + 4`.
- R10: All address sums wrap modulo 2^32. A branch can therefore cross into another 256 MB region, or wrap from 0xFFFF_FFFC to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Load `next_pc` into the PC at this edge |
| instr | input | 32 | Instruction fetched at `pc` |
| regs_eq | input | 1 | The two compared registers are equal |
| jr_target | input | 32 | Register value used by jump register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address to fetch next |
| link_addr | output | 32 | Return address for a call (`pc + 4`) |
| link_we | output | 1 | Current instruction writes the link register |

## Verification
A jump-and-link does two things in one cycle. It sends `next_pc` to the spliced jump target and it raises `link_we` with `link_addr = pc + 4`, and both are judged before the edge that retires it. The table puts the call in a high region, so a wrong splice or a link value taken from the target would show. A second overlap is a PC update together with a held or reset state. A jump register is shown with `step_en` low, and the bench checks that `next_pc` shows the target while `pc` does not move across the edge. Reset is then asserted in the middle of a run and must win over the pending redirect.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned OPC_W = 6;
  localparam int unsigned FNC_W = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JMP     = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_CALL    = 6'b000011;
  localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'b000101;
  localparam logic [FNC_W-1:0] FNC_JREG    = 6'b001000;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BR_EQ,
    FLOW_BR_NE,
    FLOW_JMP,
    FLOW_CALL,
    FLOW_JREG
  } flow_e;

  typedef struct packed {
    logic [31:0] seq;
    logic [31:0] branch;
    logic [31:0] jump;
  } cand_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FNC_W-1:0] fnc,
  output flow_e            flow
);

  always_comb begin
    flow = FLOW_SEQ;
    case (opc)
      OPC_SPECIAL: if (fnc == FNC_JREG) flow = FLOW_JREG;
      OPC_JMP:     flow = FLOW_JMP;
      OPC_CALL:    flow = FLOW_CALL;
      OPC_BR_EQ:   flow = FLOW_BR_EQ;
      OPC_BR_NE:   flow = FLOW_BR_NE;
      default:     flow = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26,
  parameter int unsigned INSN_B = 4
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [IMM_W-1:0]  offset,
  input  logic [JIDX_W-1:0] jidx,
  output cand_t             cand
);

  localparam int unsigned SH       = $clog2(INSN_B);
  localparam int unsigned REGION_W = XLEN - JIDX_W - SH;
  localparam int unsigned EXT_W    = XLEN - IMM_W - SH;

  logic [XLEN-1:0] seq_w;
  logic [XLEN-1:0] disp_w;

  // increment by one instruction, wrapping at the top of the space
  assign seq_w  = pc + XLEN'(INSN_B);
  // word offset scaled to bytes with sign carried into the upper bits
  assign disp_w = {{EXT_W{offset[IMM_W-1]}}, offset, {SH{1'b0}}};

  always_comb begin
    cand.seq    = seq_w;
    cand.branch = seq_w + disp_w;
    cand.jump   = {pc[XLEN-1 -: REGION_W], jidx, {SH{1'b0}}};
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  flow_e           flow,
  input  logic            regs_eq,
  input  cand_t           cand,
  input  logic [XLEN-1:0] jr_target,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we
);

  always_comb begin
    next_pc = cand.seq;
    case (flow)
      FLOW_BR_EQ: next_pc = regs_eq  ? cand.branch : cand.seq;
      FLOW_BR_NE: next_pc = !regs_eq ? cand.branch : cand.seq;
      FLOW_JMP,
      FLOW_CALL:  next_pc = cand.jump;
      FLOW_JREG:  next_pc = jr_target;
      default:    next_pc = cand.seq;
    endcase
  end

  assign link_we = (flow == FLOW_CALL);

endmodule

// File: rtl/npc_gen.sv
module npc_gen
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic [XLEN-1:0] instr,
  input  logic            regs_eq,
  input  logic [XLEN-1:0] jr_target,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link_addr,
  output logic            link_we
);

  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JIDX_W = 26;

  flow_e flow_w;
  cand_t cand_w;

  npc_decode u_dec (
    .opc  (instr[XLEN-1 -: OPC_W]),
    .fnc  (instr[FNC_W-1:0]),
    .flow (flow_w)
  );

  npc_targets #(
    .XLEN   (XLEN),
    .IMM_W  (IMM_W),
    .JIDX_W (JIDX_W),
    .INSN_B (4)
  ) u_tgt (
    .pc     (pc),
    .offset (instr[IMM_W-1:0]),
    .jidx   (instr[JIDX_W-1:0]),
    .cand   (cand_w)
  );

  npc_select #(
    .XLEN (XLEN)
  ) u_sel (
    .flow      (flow_w),
    .regs_eq   (regs_eq),
    .cand      (cand_w),
    .jr_target (jr_target),
    .next_pc   (next_pc),
    .link_we   (link_we)
  );

  assign link_addr = cand_w.seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= RESET_PC;
    else if (step_en) pc <= next_pc;
  end

endmodule

// File: rtl/npc_gen_chk.sv
module npc_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step_en,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic [31:0] link_addr,
  input logic        link_we
);

  logic [5:0] opc;
  logic       is_ctl;
  assign opc    = instr[31:26];
  assign is_ctl = (opc == 6'b000000) || (opc == 6'b000010) || (opc == 6'b000011) ||
                  (opc == 6'b000100) || (opc == 6'b000101);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc == $past(next_pc));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc));

  p_plain_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ctl |-> next_pc == pc + 32'd4);

  p_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b000010 || opc == 6'b000011) |-> next_pc[31:28] == pc[31:28]);

  p_call_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> opc == 6'b000011);

  p_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_addr == pc + 32'd4);

endmodule

bind npc_gen npc_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .instr     (instr),
  .pc        (pc),
  .next_pc   (next_pc),
  .link_addr (link_addr),
  .link_we   (link_we)
);

// File: tb/sim_npc_gen.sv
module sim_npc_gen;

  localparam logic [31:0] RST_PC = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] instr = 32'h0;
  logic        regs_eq = 1'b0;
  logic [31:0] jr_target = 32'h0;
  logic [31:0] pc, next_pc, link_addr;
  logic        link_we;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  npc_gen #(.RESET_PC(RST_PC)) u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr(instr),
    .regs_eq(regs_eq), .jr_target(jr_target), .pc(pc), .next_pc(next_pc),
    .link_addr(link_addr), .link_we(link_we)
  );

  // vector: {instr, regs_eq, jr_target}
  localparam int NV = 15;
  localparam logic [64:0] VEC [NV] = '{
    {32'h0000_0020, 1'b0, 32'h0},          // R3 register-format add
    {32'h1000_0002, 1'b1, 32'h0},          // R4 beq taken, skip two
    {32'h1000_0002, 1'b0, 32'h0},          // R3 beq not taken
    {32'h1400_FFFE, 1'b0, 32'h0},          // R5 bne taken backwards
    {32'h1400_FFFE, 1'b1, 32'h0},          // R5 bne not taken
    {32'h03E0_0008, 1'b1, 32'h1FFF_FFF8},  // R8 jr
    {32'h0000_0020, 1'b0, 32'h0},          // R3
    {32'h2000_0001, 1'b0, 32'h0},          // R3 immediate op, crosses region
    {32'h03E0_0008, 1'b0, 32'h2FFF_FFFC},  // R8
    {32'h0800_0100, 1'b0, 32'h0},          // R6 jump stays in region 2
    {32'h0C00_0040, 1'b0, 32'h0},          // R7 call
    {32'h2000_0008, 1'b1, 32'h0},          // R3 function bits 001000 on non-zero opcode
    {32'h03E0_0008, 1'b0, 32'hFFFF_FFFC},  // R8
    {32'h1000_0001, 1'b1, 32'h0},          // R10 wrap past top
    {32'h1000_8000, 1'b1, 32'h0}           // R10 most negative offset wraps below zero
  };

  function automatic logic [31:0] model_next(logic [31:0] p, logic [31:0] w,
                                             logic eq, logic [31:0] jr);
    logic [31:0] inc = p + 32'd4;
    logic [31:0] tgt = inc + {{14{w[15]}}, w[15:0], 2'b00};
    case (w[31:26])
      6'b000000: return (w[5:0] == 6'b001000) ? jr : inc;
      6'b000010, 6'b000011: return {p[31:28], w[25:0], 2'b00};
      6'b000100: return eq ? tgt : inc;
      6'b000101: return !eq ? tgt : inc;
      default:   return inc;
    endcase
  endfunction

  function automatic string tag_of(logic [31:0] w, logic [31:0] p);
    case (w[31:26])
      6'b000100: return (p == 32'hFFFF_FFFC || w[15:0] == 16'h8000) ? "R10" : "R4";
      6'b000101: return "R5";
      6'b000010: return "R6";
      6'b000011: return "R7";
      6'b000000: return (w[5:0] == 6'b001000) ? "R8" : "R3";
      default:   return "R3";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] mpc;
    logic [31:0] exp_n;
    @(negedge clk);
    check("R1", "pc in reset", pc, RST_PC);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pc after release", pc, RST_PC);
    check("R9", "link at reset pc", link_addr, RST_PC + 32'd4);

    mpc = RST_PC;
    step_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      instr     = VEC[i][64:33];
      regs_eq   = VEC[i][32];
      jr_target = VEC[i][31:0];
      #1;
      exp_n = model_next(mpc, instr, regs_eq, jr_target);
      check(tag_of(instr, mpc), "next_pc", next_pc, exp_n);
      check("R9", "link_addr", link_addr, mpc + 32'd4);
      check("R7", "link_we", {31'b0, link_we}, {31'b0, instr[31:26] == 6'b000011});
      @(posedge clk);
      #1;
      check("R2", "pc after enabled edge", pc, exp_n);
      mpc = exp_n;
      @(negedge clk);
    end

    // R2: with enable low, a jr shows its target but the PC holds
    step_en   = 1'b0;
    instr     = 32'h03E0_0008;
    jr_target = 32'h1234_5678;
    #1;
    check("R8", "jr target visible while held", next_pc, 32'h1234_5678);
    @(posedge clk);
    #1;
    check("R2", "pc held with enable low", pc, mpc);

    // R6: jump from the top region keeps the region bits
    @(negedge clk);
    step_en   = 1'b1;
    jr_target = 32'hF000_0000;
    @(posedge clk);
    @(negedge clk);
    instr = 32'h0BFF_FFFF;
    #1;
    check("R6", "jump keeps top region", next_pc, 32'hFFFF_FFFC);

    // R1: reset mid-run overrides the pending redirect
    rst_n = 1'b0;
    #1;
    check("R1", "async reset value", pc, RST_PC);
    @(posedge clk);
    #1;
    check("R1", "pc held in reset", pc, RST_PC);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule